// File: doc/BRIEF.md
# Task State Load Sequencer

This block carries out the central part of a hardware task switch. When started, it marks the incoming task-state descriptor as busy in memory and installs that descriptor in the task register. It then either records the outgoing task's selector as a back link, when the switch nests, or releases the outgoing descriptor. Last, it reads the incoming task's register context from the task-state segment, which can be in a 32-bit or a 16-bit layout. Validation of the segment descriptors named by the loaded selectors is left to later logic.

The sequencer talks to memory through a single request port, one access per request cycle. Read data is sampled one cycle after the read request. When the context is loaded, the block applies the side effects of a switch. It sets the nested-task flag from the switch kind, sets the task-switched bit of the machine-status register, and clears the local breakpoint enables in the debug control value. It raises a debug trap request when the incoming task asks for one, and emits a pulse that invalidates every segment cache. A task-state segment whose limit is too small ends the run with a fault pulse.

Top module: `task_load_seq`

## Requirements
- R1: After an accepted start, the first access is a byte write (mem_size 0) to the incoming descriptor address +5, carrying the incoming access byte with bit 1 set. The task register outputs then hold the new selector, base, limit and format.
- R2: The second access depends on nesting. When nesting, it is a word write (mem_size 1) of the outgoing selector to the incoming base +0. Otherwise it is a byte write to the outgoing descriptor address +5, carrying the outgoing access byte with bit 1 cleared.
- R3: A 32-bit segment with limit below 0x67, or a 16-bit segment with limit below 0x2B, produces a one-cycle fault_o after the two writes. No read is issued and no done_o follows.
- R4: In the 32-bit layout, the page-directory base is read first, at +0x1C. pdbr_load_o pulses once, with pdbr_o holding the value, only when that value differs from cur_pdbr_i.
- R5: The 32-bit read order is fixed. EIP comes from +0x20 and the flags from +0x24. The eight general registers (AX, CX, DX, BX, SP, BP, SI, DI order) come from +0x28 to +0x44 as dwords. The six selectors (ES, CS, SS, DS, FS, GS) come from +0x48 to +0x5C, 4 apart, as words. The LDT selector is a word at +0x60 and the trap byte a byte at +0x64.
- R6: In the 16-bit layout, all reads are words. EIP comes from +0x0E and the flags from +0x10. The general registers come from +0x12 to +0x20, zero-extended. ES, CS, SS and DS come from +0x22 to +0x28, and the LDT selector from +0x2A. FS and GS become zero, flag bits 31:16 (including virtual-8086 bit 17) become zero, and the trap byte is taken as zero.
- R7: The loaded flags are taken whole from memory, with no bit masked, except for the nested-task bit.
- R8: Flag bit 14 (nested task) becomes 1 when nesting and 0 on a switch that neither nests nor returns. When returning, it keeps the loaded value.
- R9: At the end, msw_o = cur_msw_i with bit 3 set and dcr_o = cur_dcr_i with mask 0x155 cleared.
- R10: trap_req_o equals bit 0 of the trap byte.
- R11: seg_inval_o pulses for exactly one cycle per completed switch.
- R12: mem_req_o lasts one cycle per access. Read data is sampled in the cycle after the request. done_o is a one-cycle pulse that comes after every output has taken its final value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a switch (accepted when idle) |
| nesting_i | input | 1 | Switch records a back link |
| returning_i | input | 1 | Switch returns to a nested task |
| new_sel_i | input | 16 | Incoming task selector |
| new_desc_addr_i | input | ADDR_W | Address of incoming descriptor |
| new_base_i | input | ADDR_W | Incoming segment base |
| new_limit_i | input | 32 | Incoming segment limit |
| new_is32_i | input | 1 | Incoming segment uses 32-bit layout |
| new_access_i | input | 8 | Incoming descriptor access byte |
| old_sel_i | input | 16 | Outgoing task selector |
| old_desc_addr_i | input | ADDR_W | Address of outgoing descriptor |
| old_access_i | input | 8 | Outgoing descriptor access byte |
| cur_pdbr_i | input | 32 | Current page-directory base |
| cur_msw_i | input | 32 | Current machine-status register |
| cur_dcr_i | input | 32 | Current debug control value |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_size_o | output | 2 | 0 byte, 1 word, 2 dword |
| mem_addr_o | output | ADDR_W | Access address |
| mem_wdata_o | output | 32 | Write data, zero-extended |
| mem_rdata_i | input | 32 | Read data, valid the cycle after request |
| fault_o | output | 1 | Task-state limit fault pulse |
| done_o | output | 1 | Completion pulse |
| tr_sel_o | output | 16 | Task register selector |
| tr_base_o | output | ADDR_W | Task register base |
| tr_limit_o | output | 32 | Task register limit |
| tr_is32_o | output | 1 | Task register format |
| eip_o | output | 32 | Loaded instruction pointer |
| eflags_o | output | 32 | Loaded flags |
| gpr_o | output | 256 | Eight general registers, AX in bits 31:0 |
| seg_o | output | 96 | Six selectors, ES in bits 15:0 up to GS |
| ldt_sel_o | output | 16 | Loaded LDT selector |
| pdbr_o | output | 32 | Page-directory base read from memory |
| pdbr_load_o | output | 1 | Page-directory reload strobe |
| msw_o | output | 32 | Updated machine-status register |
| dcr_o | output | 32 | Updated debug control value |
| trap_req_o | output | 1 | Debug trap request |
| seg_inval_o | output | 1 | Segment cache invalidate pulse |

## Verification
The bench drives both limit boundaries of each layout, one value below and exactly at the minimum. A wrong comparison would either fault on a legal segment or read past a short one. It checks the page-directory strobe with a value that differs from the current one and with a value that matches. A design that always reloads, or never does, shows up in the pulse count. Nesting, jumping and returning switches give loaded flags with bit 14 set and cleared, so a design that takes the nested-task bit from the wrong source gives the wrong flags. The 16-bit case places a set trap bit and nonzero bytes where the 32-bit fields would sit, which catches a design that leaks FS, GS, upper flag bits or the trap request across layouts.

// File: rtl/tsl_pkg.sv
package tsl_pkg;
    localparam int DATA_W  = 32;
    localparam int SEL_W   = 16;
    localparam int NUM_GPR = 8;
    localparam int NUM_SEG = 6;
    localparam int ITEM_W  = 5;

    localparam logic [31:0] LIM32_MIN      = 32'h67;
    localparam logic [31:0] LIM16_MIN      = 32'h2B;
    localparam logic [31:0] DCR_LOCAL_MASK = 32'h155;
    localparam int BUSY_BIT = 1;
    localparam int NT_BIT   = 14;
    localparam int VM_BIT   = 17;
    localparam int TS_BIT   = 3;

    // context items in read order
    localparam logic [ITEM_W-1:0] IT_PDBR  = 5'd0;
    localparam logic [ITEM_W-1:0] IT_EIP   = 5'd1;
    localparam logic [ITEM_W-1:0] IT_FLAGS = 5'd2;
    localparam logic [ITEM_W-1:0] IT_GPR0  = 5'd3;
    localparam logic [ITEM_W-1:0] IT_SEG0  = 5'd11;
    localparam logic [ITEM_W-1:0] IT_DS16  = 5'd14;
    localparam logic [ITEM_W-1:0] IT_LDT   = 5'd17;
    localparam logic [ITEM_W-1:0] IT_TRAP  = 5'd18;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2
    } acc_size_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_BUSY, ST_LINK, ST_CHECK, ST_RREQ, ST_RCAP, ST_FIN, ST_DONE
    } state_e;

    typedef struct packed {
        logic             is32;
        logic             nest;
        logic             ret;
        logic [SEL_W-1:0] sel;
        logic [SEL_W-1:0] old_sel;
        logic [7:0]       acc;
        logic [7:0]       old_acc;
    } op_t;

    function automatic logic [7:0] item_offset(logic is32, logic [ITEM_W-1:0] it);
        logic [ITEM_W-1:0] k;
        if (is32) return 8'h1C + {1'b0, it, 2'b00};
        if (it == IT_LDT) return 8'h2A;
        k = it - 5'd1;
        return 8'h0E + {2'b00, k, 1'b0};
    endfunction

    function automatic acc_size_e item_size(logic is32, logic [ITEM_W-1:0] it);
        if (!is32) return SZ_WORD;
        if (it == IT_TRAP) return SZ_BYTE;
        if (it < IT_SEG0) return SZ_DWORD;
        return SZ_WORD;
    endfunction

    function automatic logic [ITEM_W-1:0] first_item(logic is32);
        return is32 ? IT_PDBR : IT_EIP;
    endfunction

    function automatic logic is_last(logic is32, logic [ITEM_W-1:0] it);
        return it == (is32 ? IT_TRAP : IT_LDT);
    endfunction

    function automatic logic [ITEM_W-1:0] next_item(logic is32, logic [ITEM_W-1:0] it);
        if (!is32 && it == IT_DS16) return IT_LDT;
        return it + 5'd1;
    endfunction
endpackage

// File: rtl/tsl_addr_gen.sv
module tsl_addr_gen
    import tsl_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              is32_i,
    input  logic [ITEM_W-1:0] item_i,
    input  logic [ADDR_W-1:0] base_i,
    output logic [ADDR_W-1:0] addr_o,
    output acc_size_e         size_o
);
    assign addr_o = base_i + ADDR_W'(item_offset(is32_i, item_i));
    assign size_o = item_size(is32_i, item_i);
endmodule

// File: rtl/tsl_ctx_file.sv
module tsl_ctx_file
    import tsl_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clr_i,
    input  logic                       cap_i,
    input  logic                       fin_i,
    input  logic                       is32_i,
    input  logic                       nest_i,
    input  logic                       ret_i,
    input  logic [ITEM_W-1:0]          item_i,
    input  logic [DATA_W-1:0]          rdata_i,
    input  logic [31:0]                msw_i,
    input  logic [31:0]                dcr_i,
    output logic [31:0]                eip_o,
    output logic [31:0]                eflags_o,
    output logic [NUM_GPR*DATA_W-1:0]  gpr_o,
    output logic [NUM_SEG*SEL_W-1:0]   seg_o,
    output logic [SEL_W-1:0]           ldt_o,
    output logic [31:0]                msw_o,
    output logic [31:0]                dcr_o,
    output logic                       trap_o
);
    logic [DATA_W-1:0] gpr_q [NUM_GPR];
    logic [SEL_W-1:0]  seg_q [NUM_SEG];
    logic [31:0]       eip_q, eflags_q, msw_q, dcr_q;
    logic [SEL_W-1:0]  ldt_q;
    logic              trap_bit_q, trap_q;
    logic [DATA_W-1:0] val;

    // 16-bit layout loads zero-extended words
    assign val = is32_i ? rdata_i : {16'b0, rdata_i[15:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_GPR; i++) gpr_q[i] <= '0;
            for (int k = 0; k < NUM_SEG; k++) seg_q[k] <= '0;
            eip_q <= '0; eflags_q <= '0; msw_q <= '0; dcr_q <= '0;
            ldt_q <= '0; trap_bit_q <= 1'b0; trap_q <= 1'b0;
        end else begin
            if (clr_i) begin
                seg_q[4]   <= '0;
                seg_q[5]   <= '0;
                trap_bit_q <= 1'b0;
            end
            if (cap_i) begin
                if (item_i == IT_EIP)   eip_q    <= val;
                if (item_i == IT_FLAGS) eflags_q <= val;
                for (int i = 0; i < NUM_GPR; i++)
                    if (item_i == ITEM_W'(int'(IT_GPR0) + i)) gpr_q[i] <= val;
                for (int k = 0; k < NUM_SEG; k++)
                    if (item_i == ITEM_W'(int'(IT_SEG0) + k)) seg_q[k] <= rdata_i[15:0];
                if (item_i == IT_LDT)  ldt_q      <= rdata_i[15:0];
                if (item_i == IT_TRAP) trap_bit_q <= rdata_i[0];
            end
            if (fin_i) begin
                if (nest_i)      eflags_q[NT_BIT] <= 1'b1;
                else if (!ret_i) eflags_q[NT_BIT] <= 1'b0;
                msw_q  <= msw_i | (32'h1 << TS_BIT);
                dcr_q  <= dcr_i & ~DCR_LOCAL_MASK;
                trap_q <= trap_bit_q;
            end
        end
    end

    for (genvar g = 0; g < NUM_GPR; g++) begin : g_gpr
        assign gpr_o[g*DATA_W +: DATA_W] = gpr_q[g];
    end
    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        assign seg_o[s*SEL_W +: SEL_W] = seg_q[s];
    end

    assign eip_o    = eip_q;
    assign eflags_o = eflags_q;
    assign ldt_o    = ldt_q;
    assign msw_o    = msw_q;
    assign dcr_o    = dcr_q;
    assign trap_o   = trap_q;

    // R6: 16-bit layout leaves FS, GS and the upper flags at zero
    a_r6_short_layout_zero: assert property (@(posedge clk) disable iff (rst)
        (fin_i && !is32_i) |=> (seg_q[4] == '0 && seg_q[5] == '0 && !eflags_q[VM_BIT] && !trap_q));
endmodule

// File: rtl/task_load_seq.sv
module task_load_seq
    import tsl_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start_i,
    input  logic                      nesting_i,
    input  logic                      returning_i,
    input  logic [15:0]               new_sel_i,
    input  logic [ADDR_W-1:0]         new_desc_addr_i,
    input  logic [ADDR_W-1:0]         new_base_i,
    input  logic [31:0]               new_limit_i,
    input  logic                      new_is32_i,
    input  logic [7:0]                new_access_i,
    input  logic [15:0]               old_sel_i,
    input  logic [ADDR_W-1:0]         old_desc_addr_i,
    input  logic [7:0]                old_access_i,
    input  logic [31:0]               cur_pdbr_i,
    input  logic [31:0]               cur_msw_i,
    input  logic [31:0]               cur_dcr_i,
    output logic                      mem_req_o,
    output logic                      mem_we_o,
    output logic [1:0]                mem_size_o,
    output logic [ADDR_W-1:0]         mem_addr_o,
    output logic [31:0]               mem_wdata_o,
    input  logic [31:0]               mem_rdata_i,
    output logic                      fault_o,
    output logic                      done_o,
    output logic [15:0]               tr_sel_o,
    output logic [ADDR_W-1:0]         tr_base_o,
    output logic [31:0]               tr_limit_o,
    output logic                      tr_is32_o,
    output logic [31:0]               eip_o,
    output logic [31:0]               eflags_o,
    output logic [255:0]              gpr_o,
    output logic [95:0]               seg_o,
    output logic [15:0]               ldt_sel_o,
    output logic [31:0]               pdbr_o,
    output logic                      pdbr_load_o,
    output logic [31:0]               msw_o,
    output logic [31:0]               dcr_o,
    output logic                      trap_req_o,
    output logic                      seg_inval_o
);
    state_e            state_q;
    op_t               op_q;
    logic [ADDR_W-1:0] desc_q, old_desc_q;
    logic [ITEM_W-1:0] item_q;
    logic [31:0]       pdbr_q;
    logic              pdbr_load_q;
    logic              limit_bad;
    logic [ADDR_W-1:0] rd_addr;
    acc_size_e         rd_size;

    tsl_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .is32_i (op_q.is32),
        .item_i (item_q),
        .base_i (tr_base_o),
        .addr_o (rd_addr),
        .size_o (rd_size)
    );

    assign limit_bad = op_q.is32 ? (tr_limit_o < LIM32_MIN) : (tr_limit_o < LIM16_MIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            op_q        <= '0;
            desc_q      <= '0;
            old_desc_q  <= '0;
            item_q      <= '0;
            tr_sel_o    <= '0;
            tr_base_o   <= '0;
            tr_limit_o  <= '0;
            tr_is32_o   <= 1'b0;
            pdbr_q      <= '0;
            pdbr_load_q <= 1'b0;
        end else begin
            pdbr_load_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    op_q       <= '{is32: new_is32_i, nest: nesting_i, ret: returning_i,
                                    sel: new_sel_i, old_sel: old_sel_i,
                                    acc: new_access_i, old_acc: old_access_i};
                    desc_q     <= new_desc_addr_i;
                    old_desc_q <= old_desc_addr_i;
                    tr_base_o  <= new_base_i;
                    tr_limit_o <= new_limit_i;
                    state_q    <= ST_BUSY;
                end
                ST_BUSY: begin
                    tr_sel_o  <= op_q.sel;
                    tr_is32_o <= op_q.is32;
                    state_q   <= ST_LINK;
                end
                ST_LINK:  state_q <= ST_CHECK;
                ST_CHECK: begin
                    item_q  <= first_item(op_q.is32);
                    state_q <= limit_bad ? ST_IDLE : ST_RREQ;
                end
                ST_RREQ: state_q <= ST_RCAP;
                ST_RCAP: begin
                    if (item_q == IT_PDBR) begin
                        pdbr_q      <= mem_rdata_i;
                        pdbr_load_q <= (mem_rdata_i != cur_pdbr_i);
                    end
                    if (is_last(op_q.is32, item_q)) state_q <= ST_FIN;
                    else begin
                        item_q  <= next_item(op_q.is32, item_q);
                        state_q <= ST_RREQ;
                    end
                end
                ST_FIN:  state_q <= ST_DONE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_size_o  = SZ_BYTE;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        unique case (state_q)
            ST_BUSY: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = desc_q + ADDR_W'(5);
                mem_wdata_o = {24'b0, op_q.acc | 8'(1 << BUSY_BIT)};
            end
            ST_LINK: begin
                mem_req_o = 1'b1;
                mem_we_o  = 1'b1;
                if (op_q.nest) begin
                    mem_size_o  = SZ_WORD;
                    mem_addr_o  = tr_base_o;
                    mem_wdata_o = {16'b0, op_q.old_sel};
                end else begin
                    mem_addr_o  = old_desc_q + ADDR_W'(5);
                    mem_wdata_o = {24'b0, op_q.old_acc & ~8'(1 << BUSY_BIT)};
                end
            end
            ST_RREQ: begin
                mem_req_o  = 1'b1;
                mem_size_o = rd_size;
                mem_addr_o = rd_addr;
            end
            default: ;
        endcase
    end

    tsl_ctx_file u_ctx (
        .clk      (clk),
        .rst      (rst),
        .clr_i    (state_q == ST_CHECK),
        .cap_i    (state_q == ST_RCAP),
        .fin_i    (state_q == ST_FIN),
        .is32_i   (op_q.is32),
        .nest_i   (op_q.nest),
        .ret_i    (op_q.ret),
        .item_i   (item_q),
        .rdata_i  (mem_rdata_i),
        .msw_i    (cur_msw_i),
        .dcr_i    (cur_dcr_i),
        .eip_o    (eip_o),
        .eflags_o (eflags_o),
        .gpr_o    (gpr_o),
        .seg_o    (seg_o),
        .ldt_o    (ldt_sel_o),
        .msw_o    (msw_o),
        .dcr_o    (dcr_o),
        .trap_o   (trap_req_o)
    );

    assign fault_o     = (state_q == ST_CHECK) && limit_bad;
    assign done_o      = (state_q == ST_DONE);
    assign seg_inval_o = (state_q == ST_DONE);
    assign pdbr_o      = pdbr_q;
    assign pdbr_load_o = pdbr_load_q;

    // R1: busy mark is the first access after start
    a_r1_busy_first: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && start_i) |=> (mem_req_o && mem_we_o && mem_size_o == SZ_BYTE
            && mem_addr_o == $past(new_desc_addr_i) + ADDR_W'(5)
            && mem_wdata_o[BUSY_BIT]));
    // R3: a fault returns to idle with nothing further
    a_r3_fault_quiet: assert property (@(posedge clk) disable iff (rst)
        fault_o |=> (!mem_req_o && !done_o));
    // R12: done is a single-cycle pulse, and each read request lasts one cycle
    a_r12_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    a_r12_read_single: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && !mem_we_o) |=> !mem_req_o);
    // R9: status and debug side effects visible at done
    a_r9_side_effects: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (msw_o[TS_BIT] && (dcr_o & DCR_LOCAL_MASK) == '0));
    // R8: nesting leaves the nested-task flag set
    a_r8_nt_nest: assert property (@(posedge clk) disable iff (rst)
        (done_o && op_q.nest) |-> eflags_o[NT_BIT]);
endmodule

// File: tb/tb_task_load_seq.sv
module tb_task_load_seq;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic        start_i = 0, nesting_i = 0, returning_i = 0, new_is32_i = 0;
    logic [15:0] new_sel_i = 0, old_sel_i = 0;
    logic [31:0] new_desc_addr_i = 0, new_base_i = 0, new_limit_i = 0, old_desc_addr_i = 0;
    logic [7:0]  new_access_i = 0, old_access_i = 0;
    logic [31:0] cur_pdbr_i = 0, cur_msw_i = 0, cur_dcr_i = 0, mem_rdata_i = 0;
    logic        mem_req_o, mem_we_o, fault_o, done_o, tr_is32_o, pdbr_load_o, trap_req_o, seg_inval_o;
    logic [1:0]  mem_size_o;
    logic [31:0] mem_addr_o, mem_wdata_o, tr_base_o, tr_limit_o, eip_o, eflags_o;
    logic [31:0] pdbr_o, msw_o, dcr_o;
    logic [15:0] tr_sel_o, ldt_sel_o;
    logic [255:0] gpr_o;
    logic [95:0]  seg_o;

    task_load_seq dut (.*);

    typedef struct packed { logic we; logic [1:0] sz; logic [31:0] addr; logic [31:0] data; } acc_t;
    acc_t exp_q[$];
    logic [7:0] mem [logic [31:0]];
    int checks = 0, fails = 0;
    int done_cnt, fault_cnt, pdbr_cnt, inval_cnt;
    string cur_req;

    function automatic logic [7:0] rd8(logic [31:0] a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction
    function automatic logic [31:0] rd32(logic [31:0] a);
        return {rd8(a + 3), rd8(a + 2), rd8(a + 1), rd8(a)};
    endfunction
    function automatic logic [31:0] rd16(logic [31:0] a);
        return {16'b0, rd8(a + 1), rd8(a)};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: scoreboard pops expected accesses, serves reads, counts pulses
    always @(negedge clk) begin
        if (!rst) begin
            if (done_o) done_cnt++;
            if (fault_o) fault_cnt++;
            if (pdbr_load_o) pdbr_cnt++;
            if (seg_inval_o) inval_cnt++;
            if (mem_req_o) begin
                acc_t got, e;
                got = '{we: mem_we_o, sz: mem_size_o, addr: mem_addr_o,
                        data: mem_we_o ? mem_wdata_o : 32'h0};
                if (exp_q.size() == 0) chk({cur_req, " unexpected access"}, got.addr, 32'hFFFF_FFFF);
                else begin
                    e = exp_q.pop_front();
                    chk({cur_req, " access order"}, {got.we, 29'b0, got.sz}, {e.we, 29'b0, e.sz});
                    chk({cur_req, " access addr"}, got.addr, e.addr);
                    if (e.we) chk({cur_req, " write data"}, got.data, e.data);
                end
                if (mem_we_o) begin
                    mem[mem_addr_o] = mem_wdata_o[7:0];
                    if (mem_size_o != 2'd0) mem[mem_addr_o + 1] = mem_wdata_o[15:8];
                end else mem_rdata_i <= rd32(mem_addr_o);
            end
        end
    end

    task automatic fill(logic [31:0] base, int seed);
        for (int o = 0; o < 'h68; o++) mem[base + o] = 8'(seed * 7 + o * 13 + 1);
    endtask
    task automatic put32(logic [31:0] a, logic [31:0] v);
        for (int b = 0; b < 4; b++) mem[a + b] = v[b*8 +: 8];
    endtask

    task automatic run_case(string tag, bit is32, bit nest, bit ret, logic [31:0] base,
                            logic [31:0] lim, logic [31:0] pdbr_cur);
        bit bad;
        acc_t a;
        logic [31:0] exp_fl, exp_pd;
        cur_req = tag;
        bad = is32 ? (lim < 32'h67) : (lim < 32'h2B);
        exp_pd = rd32(base + 32'h1C);
        // driver: expected accesses (R1, R2, R4, R5, R6)
        exp_q.push_back('{we: 1, sz: 0, addr: 32'h2045, data: 32'h8B});
        if (nest) a = '{we: 1, sz: 1, addr: base, data: 32'h0030};
        else      a = '{we: 1, sz: 0, addr: 32'h2035, data: 32'h89};
        exp_q.push_back(a);
        if (!bad) begin
            if (is32) for (int i = 0; i <= 18; i++)
                exp_q.push_back('{we: 0, sz: (i <= 10) ? 2'd2 : (i == 18 ? 2'd0 : 2'd1),
                                  addr: base + 32'h1C + 4 * i, data: 0});
            else begin
                for (int i = 0; i < 14; i++)
                    exp_q.push_back('{we: 0, sz: 1, addr: base + 32'h0E + 2 * i, data: 0});
                exp_q.push_back('{we: 0, sz: 1, addr: base + 32'h2A, data: 0});
            end
        end
        done_cnt = 0; fault_cnt = 0; pdbr_cnt = 0; inval_cnt = 0;
        @(negedge clk);
        start_i = 1; nesting_i = nest; returning_i = ret; new_is32_i = is32;
        new_sel_i = 16'h0040; new_desc_addr_i = 32'h2040; new_base_i = base; new_limit_i = lim;
        new_access_i = 8'h89; old_sel_i = 16'h0030; old_desc_addr_i = 32'h2030; old_access_i = 8'h8B;
        cur_pdbr_i = pdbr_cur; cur_msw_i = 32'h11; cur_dcr_i = 32'h3FF;
        @(negedge clk);
        start_i = 0;
        for (int c = 0; c < 200 && done_cnt == 0 && fault_cnt == 0; c++) @(negedge clk);
        repeat (2) @(negedge clk);
        chk({tag, " R2/R5/R6 all accesses seen"}, exp_q.size(), 0);
        exp_q.delete();
        chk({tag, " R1 tr_sel"}, tr_sel_o, 32'h40);
        chk({tag, " R1 tr_base"}, tr_base_o, base);
        chk({tag, " R1 tr_limit"}, tr_limit_o, lim);
        chk({tag, " R1 tr_is32"}, tr_is32_o, is32);
        if (bad) begin
            chk({tag, " R3 fault pulse"}, fault_cnt, 1);
            chk({tag, " R3 no done"}, done_cnt, 0);
            return;
        end
        chk({tag, " R3 no fault"}, fault_cnt, 0);
        chk({tag, " R12 one done"}, done_cnt, 1);
        chk({tag, " R11 one inval"}, inval_cnt, 1);
        chk({tag, " R9 msw"}, msw_o, 32'h19);
        chk({tag, " R9 dcr"}, dcr_o, 32'h2AA);
        if (is32) begin
            chk({tag, " R4 pdbr strobe"}, pdbr_cnt, (exp_pd != pdbr_cur) ? 1 : 0);
            if (exp_pd != pdbr_cur) chk({tag, " R4 pdbr value"}, pdbr_o, exp_pd);
            chk({tag, " R5 eip"}, eip_o, rd32(base + 32'h20));
            exp_fl = rd32(base + 32'h24);
            for (int i = 0; i < 8; i++) chk({tag, " R5 gpr"}, gpr_o[i*32 +: 32], rd32(base + 32'h28 + 4 * i));
            for (int k = 0; k < 6; k++) chk({tag, " R5 sel"}, seg_o[k*16 +: 16], rd16(base + 32'h48 + 4 * k));
            chk({tag, " R5 ldt"}, ldt_sel_o, rd16(base + 32'h60));
            chk({tag, " R10 trap"}, trap_req_o, rd8(base + 32'h64) & 8'h1);
        end else begin
            chk({tag, " R4 no strobe in 16-bit"}, pdbr_cnt, 0);
            chk({tag, " R6 eip"}, eip_o, rd16(base + 32'h0E));
            exp_fl = rd16(base + 32'h10);
            for (int i = 0; i < 8; i++) chk({tag, " R6 gpr"}, gpr_o[i*32 +: 32], rd16(base + 32'h12 + 2 * i));
            for (int k = 0; k < 6; k++)
                chk({tag, " R6 sel"}, seg_o[k*16 +: 16], (k < 4) ? rd16(base + 32'h22 + 2 * k) : 32'h0);
            chk({tag, " R6 ldt"}, ldt_sel_o, rd16(base + 32'h2A));
            chk({tag, " R6 trap forced zero"}, trap_req_o, 0);
        end
        if (nest) exp_fl[14] = 1'b1;
        else if (!ret) exp_fl[14] = 1'b0;
        chk({tag, " R7 R8 eflags"}, eflags_o, exp_fl);
    endtask

    initial begin
        cur_req = "reset";
        repeat (3) @(negedge clk);
        chk("R12 reset done", done_o, 0);
        chk("R12 reset mem_req", mem_req_o, 0);
        chk("R3 reset fault", fault_o, 0);
        chk("R10 reset trap", trap_req_o, 0);
        rst = 0;
        // 32-bit nesting at exact minimum limit, new page directory, trap bit set
        fill(32'h1_0000, 1);
        put32(32'h1_0024, 32'h0002_0202);
        mem[32'h1_0064] = 8'h01;
        run_case("c32_nest", 1, 1, 0, 32'h1_0000, 32'h67, 32'h0);
        // 16-bit jump, loaded NT set, trap byte present but ignored
        fill(32'h2_0000, 2);
        put32(32'h2_0010, 32'hFFFF_4ED7);
        mem[32'h2_0064] = 8'hFF;
        run_case("c16_jump", 0, 0, 0, 32'h2_0000, 32'h2B, 32'h0);
        // 32-bit return, same page directory, all flags set, trap clear
        fill(32'h3_0000, 3);
        put32(32'h3_001C, 32'h0055_A000);
        put32(32'h3_0024, 32'hFFFF_FFFF);
        mem[32'h3_0064] = 8'hFE;
        run_case("c32_ret", 1, 0, 1, 32'h3_0000, 32'h1000, 32'h0055_A000);
        // 16-bit return keeps loaded NT clear
        fill(32'h4_0000, 4);
        put32(32'h4_0010, 32'h0000_0ED7);
        run_case("c16_ret", 0, 0, 1, 32'h4_0000, 32'h2C, 32'h0);
        // limit one below minimum
        run_case("c32_short", 1, 0, 0, 32'h5_0000, 32'h66, 32'h0);
        run_case("c16_short", 0, 1, 0, 32'h6_0000, 32'h2A, 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired in %s", cur_req);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule